// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned operands of a parameterised width. It reports whether the first operand is greater than, equal to or less than the second. The decision is made by a chain of single-bit cells. The chain starts at the most significant bit and ends at the least significant bit. Each cell passes a three-line verdict (greater, equal, less) to the next cell down. Once a cell finds a bit where the operands differ, the verdict is fixed, and every cell below it passes that verdict on unchanged.

The top cell does not use a constant seed. It takes its verdict from three cascade inputs. A unit used on its own ties these inputs to greater=0, equal=1, less=0. To build a wider comparator, place several units side by side and feed the verdict outputs of the more significant unit into the cascade inputs of the less significant unit.

An optional output gives the smaller of the two operands. A width-wide multiplexer drives it, steered by the final less-than verdict. The whole block is combinational.

Top module: `mag_cmp_cascade`

## Requirements
- R1: With the standalone seed (greater=0, equal=1, less=0) and identical operands, only the equal output is high.
- R2: With the standalone seed, the greater output is high exactly when the operands differ and, at the most significant differing bit, the first operand holds 1 and the second holds 0 (for example 0x0B against 0x09, decided at bit 1).
- R3: With the standalone seed, the less output is high exactly when, at the most significant differing bit, the first operand holds 0 and the second holds 1.
- R4: When the greater cascade input is high, the greater output is high whatever the operand values are.
- R5: When the less cascade input is high, the less output is high whatever the operand values are.
- R6: When exactly one cascade input is high, exactly one of the three outputs is high.
- R7: When the minimum output is enabled, it equals the first operand if the less output is high, and the second operand otherwise.
- R8: When the equal cascade input is low, the equal output is low even for identical operands. An all-zero seed therefore gives all three outputs low.
- R9: Two units of half width, the upper one seeded standalone and feeding its verdict into the lower one, give the same verdict as one full-width unit on the concatenated operands.
- R10: When the minimum output is disabled by parameter, the minimum output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand, unsigned |
| opb_i | input | WIDTH | Second operand, unsigned |
| casc_gt_i | input | 1 | Verdict from a more significant unit: greater |
| casc_eq_i | input | 1 | Verdict from a more significant unit: equal |
| casc_lt_i | input | 1 | Verdict from a more significant unit: less |
| a_gt_b_o | output | 1 | Final verdict: first operand greater |
| a_eq_b_o | output | 1 | Final verdict: operands equal |
| a_lt_b_o | output | 1 | Final verdict: first operand less |
| min_o | output | WIDTH | Smaller operand when MIN_EN=1, zero otherwise |

## Verification
The bench builds one unit at the default width of 8 with the minimum output enabled. It builds two more units at width 4 with the minimum output disabled. The 8-bit unit handles the vector table and covers these cases: decisions at the top bit, at the bottom bit and in the middle, forced verdicts through the cascade inputs, and the all-zero seed. The pair of 4-bit units is chained and run on the same operands, so the cascade path between units is compared against the single wide unit. The same pair also shows the disabled variant of the minimum output holding zero.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // Verdict carried between bit cells and between chained units.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;

  localparam verdict_t VERDICT_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/mag_cmp_bit_cell.sv
module mag_cmp_bit_cell
  import mag_cmp_pkg::*;
(
  input  verdict_t up_i,
  input  logic     a_bit_i,
  input  logic     b_bit_i,
  output verdict_t down_o
);

  logic a_wins;
  logic b_wins;
  logic bits_same;

  always_comb begin
    a_wins    = a_bit_i & ~b_bit_i;
    b_wins    = ~a_bit_i & b_bit_i;
    bits_same = ~(a_bit_i ^ b_bit_i);
    down_o.gt = up_i.gt | (up_i.eq & a_wins);
    down_o.lt = up_i.lt | (up_i.eq & b_wins);
    down_o.eq = up_i.eq & bits_same;
  end

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  verdict_t         seed_i,
  output verdict_t         result_o
);

  localparam int TOP = WIDTH;

  verdict_t link [TOP:0];

  assign link[TOP] = seed_i;

  for (genvar gi = WIDTH - 1; gi >= 0; gi--) begin : g_cell
    mag_cmp_bit_cell u_cell (
      .up_i    (link[gi+1]),
      .a_bit_i (a_i[gi]),
      .b_bit_i (b_i[gi]),
      .down_o  (link[gi])
    );
  end

  assign result_o = link[0];

endmodule

// File: rtl/mag_cmp_min_sel.sv
module mag_cmp_min_sel #(
  parameter int WIDTH  = 8,
  parameter bit MIN_EN = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_less_i,
  output logic [WIDTH-1:0] min_o
);

  if (MIN_EN) begin : g_mux
    always_comb begin
      if (a_less_i) min_o = a_i;
      else          min_o = b_i;
    end
  end else begin : g_off
    assign min_o = '0;
  end

endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit MIN_EN = 1'b1
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             casc_gt_i,
  input  logic             casc_eq_i,
  input  logic             casc_lt_i,
  output logic             a_gt_b_o,
  output logic             a_eq_b_o,
  output logic             a_lt_b_o,
  output logic [WIDTH-1:0] min_o
);

  verdict_t seed;
  verdict_t result;

  assign seed.gt = casc_gt_i;
  assign seed.eq = casc_eq_i;
  assign seed.lt = casc_lt_i;

  mag_cmp_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .seed_i   (seed),
    .result_o (result)
  );

  assign a_gt_b_o = result.gt;
  assign a_eq_b_o = result.eq;
  assign a_lt_b_o = result.lt;

  mag_cmp_min_sel #(.WIDTH(WIDTH), .MIN_EN(MIN_EN)) u_min (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .a_less_i (result.lt),
    .min_o    (min_o)
  );

endmodule

// File: rtl/mag_cmp_cascade_chk.sv
module mag_cmp_cascade_chk #(
  parameter int WIDTH  = 8,
  parameter bit MIN_EN = 1'b1
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic             casc_gt_i,
  input logic             casc_eq_i,
  input logic             casc_lt_i,
  input logic             a_gt_b_o,
  input logic             a_eq_b_o,
  input logic             a_lt_b_o,
  input logic [WIDTH-1:0] min_o
);

  logic standalone;
  assign standalone = ~casc_gt_i & casc_eq_i & ~casc_lt_i;

  always_comb begin
    if ($countones({casc_gt_i, casc_eq_i, casc_lt_i}) == 1)
      AST_ONE_VERDICT: assert ($countones({a_gt_b_o, a_eq_b_o, a_lt_b_o}) == 1); // R6
    if (a_eq_b_o)
      AST_EQ_NEEDS_SEED: assert (casc_eq_i && (opa_i == opb_i)); // R8
    if (standalone)
      AST_EQ_STANDALONE: assert (a_eq_b_o == (opa_i == opb_i)); // R1
    if (standalone)
      AST_GT_STANDALONE: assert (a_gt_b_o == (opa_i > opb_i)); // R2
    if (standalone)
      AST_LT_STANDALONE: assert (a_lt_b_o == (opa_i < opb_i)); // R3
    if (casc_gt_i)
      AST_GT_FORCED: assert (a_gt_b_o); // R4
    if (casc_lt_i)
      AST_LT_FORCED: assert (a_lt_b_o); // R5
    if (MIN_EN && standalone)
      AST_MIN_SMALLEST: assert ((min_o <= opa_i) && (min_o <= opb_i)); // R7
    if (!MIN_EN)
      AST_MIN_OFF_ZERO: assert (min_o == '0); // R10
  end

endmodule

bind mag_cmp_cascade mag_cmp_cascade_chk #(.WIDTH(WIDTH), .MIN_EN(MIN_EN)) i_chk (
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .casc_gt_i (casc_gt_i),
  .casc_eq_i (casc_eq_i),
  .casc_lt_i (casc_lt_i),
  .a_gt_b_o  (a_gt_b_o),
  .a_eq_b_o  (a_eq_b_o),
  .a_lt_b_o  (a_lt_b_o),
  .min_o     (min_o)
);

// File: tb/test_mag_cmp_cascade.sv
`timescale 1ns/1ps
module test_mag_cmp_cascade;

  localparam int W  = 8;
  localparam int HW = W / 2;
  localparam int NV = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] opa, opb, min_w;
  logic sg, se, sl, gt, eq, lt;
  logic hgt, heq, hlt, lgt, leq, llt;
  logic [HW-1:0] hmin, lmin;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  mag_cmp_cascade #(.WIDTH(W), .MIN_EN(1'b1)) i_mag_cmp_cascade (
    .opa_i(opa), .opb_i(opb), .casc_gt_i(sg), .casc_eq_i(se), .casc_lt_i(sl),
    .a_gt_b_o(gt), .a_eq_b_o(eq), .a_lt_b_o(lt), .min_o(min_w)
  );

  mag_cmp_cascade #(.WIDTH(HW), .MIN_EN(1'b0)) i_hi (
    .opa_i(opa[W-1:HW]), .opb_i(opb[W-1:HW]),
    .casc_gt_i(1'b0), .casc_eq_i(1'b1), .casc_lt_i(1'b0),
    .a_gt_b_o(hgt), .a_eq_b_o(heq), .a_lt_b_o(hlt), .min_o(hmin)
  );

  mag_cmp_cascade #(.WIDTH(HW), .MIN_EN(1'b0)) i_lo (
    .opa_i(opa[HW-1:0]), .opb_i(opb[HW-1:0]),
    .casc_gt_i(hgt), .casc_eq_i(heq), .casc_lt_i(hlt),
    .a_gt_b_o(lgt), .a_eq_b_o(leq), .a_lt_b_o(llt), .min_o(lmin)
  );

  // Entry: operand a, operand b, seed {gt,eq,lt}
  localparam logic [18:0] VEC [NV] = '{
    {8'h0B, 8'h09, 3'b010},
    {8'h09, 8'h0B, 3'b010},
    {8'h5A, 8'h5A, 3'b010},
    {8'h00, 8'hFF, 3'b010},
    {8'hFF, 8'h00, 3'b010},
    {8'h80, 8'h7F, 3'b010},
    {8'h7F, 8'h80, 3'b010},
    {8'hFE, 8'hFF, 3'b010},
    {8'h3C, 8'h3C, 3'b100},
    {8'h00, 8'hFF, 3'b100},
    {8'hFF, 8'h00, 3'b001},
    {8'h3C, 8'h3C, 3'b000}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] ea, eb;
    logic s_g, s_e, s_l, xg, xe, xl;
    opa = '0; opb = '0; sg = 1'b0; se = 1'b1; sl = 1'b0;
    @(negedge clk);
    // R1: idle standalone state, equal operands
    check("R1 idle", {5'd0, gt, eq, lt}, 8'b010);
    check("R7 idle min", min_w, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      {ea, eb, s_g, s_e, s_l} = VEC[i];
      opa = ea; opb = eb; sg = s_g; se = s_e; sl = s_l;
      @(negedge clk);
      xg = s_g | (s_e & (ea > eb));
      xl = s_l | (s_e & (ea < eb));
      xe = s_e & (ea == eb);
      check("R2/R4 gt", {7'd0, gt}, {7'd0, xg});
      check("R3/R5 lt", {7'd0, lt}, {7'd0, xl});
      check("R1/R8 eq", {7'd0, eq}, {7'd0, xe});
      check("R7 min", min_w, xl ? ea : eb);
      if ($countones({s_g, s_e, s_l}) == 1)
        check("R6 one-hot", 8'($countones({gt, eq, lt})), 8'd1);
      // R9: chained half-width pair against the full unit
      if (s_e && !s_g && !s_l)
        check("R9 chain", {5'd0, lgt, leq, llt}, {5'd0, xg, xe, xl});
      check("R10 min off", {hmin, lmin}, 8'h00);
    end

    // R8: all-zero seed, different operands
    @(posedge clk);
    opa = 8'h12; opb = 8'h34; sg = 1'b0; se = 1'b0; sl = 1'b0;
    @(negedge clk);
    check("R8 zero seed", {5'd0, gt, eq, lt}, 8'b000);
    check("R7 min zero seed", min_w, 8'h34);

    // R5 and R7: forced less verdict picks operand a
    @(posedge clk);
    opa = 8'hF0; opb = 8'h01; sg = 1'b0; se = 1'b0; sl = 1'b1;
    @(negedge clk);
    check("R5 forced lt", {5'd0, gt, eq, lt}, 8'b001);
    check("R7 min forced", min_w, 8'hF0);

    // R9: difference only in the lower half, chained pair
    @(posedge clk);
    opa = 8'hA3; opb = 8'hA7; sg = 1'b0; se = 1'b1; sl = 1'b0;
    @(negedge clk);
    check("R9 low half", {5'd0, lgt, leq, llt}, 8'b001);
    check("R3 low half", {5'd0, gt, eq, lt}, 8'b001);

    finish_run();
  end

endmodule